// File: doc/BRIEF.md
# Dual-Mode Display Memory Write Controller

This block takes 6-bit character codes from a processor bus and places them in an eight-word display memory. A scan engine reads that memory through a separate read port. The write strobe is formed from an active-low write line and an active-low chip select. The mode level sampled when the strobe opens decides where the code goes. In random mode, three address lines pick the word. In sequential mode, an internal pointer picks the word and steps forward after each accepted write.

In sequential mode the shared control pins change roles. The lowest pin becomes a serial enable, the middle pin becomes an active-low clear, and the top pin carries a full flag, which is given as a value and an output enable. Several controllers can be chained: each one fills its eight words and then raises full, which hands the stream to the next controller. A busy output tells the scan engine to blank the display while a write that will touch memory is in progress. A standby input silences the full-flag driver.

The strobe and the clear pin pass through synchronizers into the single system clock. Edges are found by comparing the synchronized strobe with its previous sample.

Top module: `disp_write_ctrl`

## Requirements
- R1: The strobe is active only while both `wrN` and `csN` are low. Its opening and closing edges take effect at the third rising clock edge after the input change (two synchronizer stages plus edge detection). With `csN` high, `wrN` activity does nothing.
- R2: `modeSel` is latched when the strobe opens: 1 selects sequential mode and 0 selects random mode. The latched mode changes only at that point. Reset selects random mode.
- R3: In random mode, `addrIn[2:0]` is latched when the strobe opens. Changes on `addrIn` or `modeSel` after that point do not alter where the write lands.
- R4: `dataIn` is sampled when the strobe closes and stored in the selected word. `rdData` always shows the word selected by `rdAddr`. After reset, every word holds 6'b100000.
- R5: In sequential mode, `addrIn[0]` is latched as the serial enable when the strobe opens. The write stores only when this latched enable is 1 and full is 0. Otherwise the write leaves the memory unchanged.
- R6: In sequential mode, the pointer supplies the word index, starting at word 0. The pointer advances by one when each accepted write closes.
- R7: `fullOut` rises when the eighth sequential write is accepted. It stays high, refusing further sequential stores, until a clear.
- R8: While sequential mode is latched and the synchronized `addrIn[1]` is 0, the pointer returns to 0 and every word becomes 6'b100000. This clear takes priority over a write in the same cycle.
- R9: `fullOe` becomes 1 when a strobe that latched sequential mode closes. It becomes 0 when a strobe opens with `modeSel` at 0. It is 0 after reset and never 1 while random mode is latched.
- R10: `wrBusy` rises when the strobe opens and falls when it closes. In sequential mode it rises only if the enable pin is 1 and full is 0 at that moment. In random mode it always rises.
- R11: `standby` forces `fullOe` to 0 and has no effect on the memory, the pointer or `fullOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrN | input | 1 | Write strobe, active low |
| csN | input | 1 | Chip select, active low |
| modeSel | input | 1 | 1 = sequential, 0 = random, latched at strobe open |
| dataIn | input | 6 | Character code, sampled at strobe close |
| addrIn | input | 3 | Random: word address. Sequential: [0] enable, [1] clear (active low) |
| standby | input | 1 | Forces the full-flag output enable off |
| rdAddr | input | 3 | Scan read address |
| rdData | output | 6 | Code stored at `rdAddr` |
| fullOut | output | 1 | Sequential full flag value |
| fullOe | output | 1 | Output enable for the full flag driver |
| wrBusy | output | 1 | Write in progress, display blanking request |

## Verification
A wrong pointer or a wrong latched enable shows up on `rdData` as a code in the wrong word, or as a missing code. The reference model sweeps `rdAddr` across all eight words every eight cycles, so such an error is visible within eight cycles of the strobe closing. A full flag that is wrong, whether stuck or released early, appears at once on `fullOut`. On the next sequential write it also shows as a spurious store or a missing `wrBusy` pulse. A wrong mode latch shows on `fullOe` within three cycles of the strobe edge that should have moved it.

// File: rtl/disp_write_pkg.sv
package disp_write_pkg;
  localparam int DEPTH  = 8;
  localparam int CODE_W = 6;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = $clog2(DEPTH + 1);
  localparam logic [CODE_W-1:0] BLANK_CODE = 6'b100000;

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              clrAll;
    logic [ADDR_W-1:0] wrAddr;
  } wrStrobe_t;
endpackage

// File: rtl/disp_write_sync.sv
module disp_write_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/disp_write_fsm.sv
module disp_write_fsm
  import disp_write_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrN,
  input  logic              csN,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              standby,
  output wrStrobe_t         strobes,
  output logic              fullOut,
  output logic              fullOe,
  output logic              wrBusy,
  output logic              modeSeq
);
  localparam int SEN_BIT = 0;
  localparam int CLR_BIT = 1;

  logic strobeSync, strobePrev, clrSync;
  logic openPulse, closePulse, clrAll, accept, full;
  logic senLat, oeReg, busyReg;
  logic [ADDR_W-1:0] addrLat;
  logic [PTR_W-1:0]  seqPtr;

  disp_write_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_strobeSync (
    .clk(clk), .rst_n(rst_n), .d(~wrN & ~csN), .q(strobeSync));

  disp_write_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_clrSync (
    .clk(clk), .rst_n(rst_n), .d(addrIn[CLR_BIT]), .q(clrSync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobePrev <= 1'b0;
    else        strobePrev <= strobeSync;
  end

  assign openPulse  = strobeSync & ~strobePrev;
  assign closePulse = ~strobeSync & strobePrev;
  assign full       = (seqPtr == PTR_W'(DEPTH));
  assign clrAll     = modeSeq & ~clrSync;
  assign accept     = closePulse & ~clrAll & (~modeSeq | (senLat & ~full));

  // Latches taken as the strobe opens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeSeq <= 1'b0;
      senLat  <= 1'b0;
      addrLat <= '0;
    end else if (openPulse) begin
      modeSeq <= modeSel;
      senLat  <= addrIn[SEN_BIT];
      addrLat <= addrIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seqPtr <= '0;
    else if (clrAll)           seqPtr <= '0;
    else if (accept & modeSeq) seqPtr <= seqPtr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busyReg <= 1'b0;
    else if (openPulse)             busyReg <= ~modeSel | (addrIn[SEN_BIT] & ~full);
    else if (closePulse)            busyReg <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     oeReg <= 1'b0;
    else if (openPulse & ~modeSel)  oeReg <= 1'b0;
    else if (closePulse & modeSeq)  oeReg <= 1'b1;
  end

  assign strobes.wrEn   = accept;
  assign strobes.clrAll = clrAll;
  assign strobes.wrAddr = modeSeq ? seqPtr[ADDR_W-1:0] : addrLat;
  assign fullOut        = full;
  assign fullOe         = oeReg & ~standby;
  assign wrBusy         = busyReg;
endmodule

// File: rtl/disp_write_mem.sv
module disp_write_mem
  import disp_write_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wrStrobe_t         strobes,
  input  logic [CODE_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CODE_W-1:0] rdData
);
  logic [CODE_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= BLANK_CODE;
    end else if (strobes.clrAll) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= BLANK_CODE;
    end else if (strobes.wrEn) begin
      words[strobes.wrAddr] <= dataIn;
    end
  end

  assign rdData = words[rdAddr];
endmodule

// File: rtl/disp_write_ctrl.sv
module disp_write_ctrl
  import disp_write_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrN,
  input  logic              csN,
  input  logic              modeSel,
  input  logic [CODE_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              standby,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CODE_W-1:0] rdData,
  output logic              fullOut,
  output logic              fullOe,
  output logic              wrBusy
);
  wrStrobe_t strobes;
  logic      modeSeq;

  disp_write_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wrN(wrN), .csN(csN), .modeSel(modeSel),
    .addrIn(addrIn), .standby(standby), .strobes(strobes),
    .fullOut(fullOut), .fullOe(fullOe), .wrBusy(wrBusy), .modeSeq(modeSeq));

  disp_write_mem u_mem (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .dataIn(dataIn),
    .rdAddr(rdAddr), .rdData(rdData));
endmodule

// File: rtl/disp_write_chk.sv
module disp_write_chk (
  input logic clk,
  input logic rst_n,
  input logic standby,
  input logic fullOut,
  input logic fullOe,
  input logic wrBusy,
  input logic wrEn,
  input logic clrAll,
  input logic modeSeq
);
  a_r6_full_blocks_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSeq && fullOut) |-> !wrEn);

  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fullOut && !clrAll) |=> fullOut);

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clrAll |=> !fullOut);

  a_r9_random_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !modeSeq |-> !fullOe);

  a_r10_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> wrBusy);

  a_r11_standby_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !fullOe);
endmodule

bind disp_write_ctrl disp_write_chk u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .fullOut(fullOut),
  .fullOe(fullOe), .wrBusy(wrBusy), .wrEn(strobes.wrEn),
  .clrAll(strobes.clrAll), .modeSeq(modeSeq));

// File: tb/disp_write_ctrl_bench.sv
module disp_write_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrN = 1'b1, csN = 1'b0, modeSel = 1'b0, standby = 1'b0;
  logic [5:0] dataIn = '0;
  logic [2:0] addrIn = 3'b010;
  logic [2:0] rdAddr = '0;
  logic [5:0] rdData;
  logic       fullOut, fullOe, wrBusy;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  disp_write_ctrl u_disp_write_ctrl (
    .clk(clk), .rst_n(rst_n), .wrN(wrN), .csN(csN), .modeSel(modeSel),
    .dataIn(dataIn), .addrIn(addrIn), .standby(standby), .rdAddr(rdAddr),
    .rdData(rdData), .fullOut(fullOut), .fullOe(fullOe), .wrBusy(wrBusy));

  // Behavioural reference model
  int  mMem[8];
  int  mCount;
  bit  mSeq, mSen, mOe, mBusy;
  int  mAddr;
  bit  sw1, sw2, sw3, sc1, sc2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mMem[i]) mMem[i] = 'h20;
      mCount = 0; mSeq = 0; mSen = 0; mOe = 0; mBusy = 0; mAddr = 0;
      sw1 = 0; sw2 = 0; sw3 = 0; sc1 = 1; sc2 = 1;
    end else begin
      bit opening, closing, clearing, wasFull;
      opening  = sw2 && !sw3;
      closing  = !sw2 && sw3;
      clearing = mSeq && !sc2;
      wasFull  = (mCount == 8);
      if (clearing) begin
        foreach (mMem[i]) mMem[i] = 'h20;
        mCount = 0;
      end else if (closing) begin
        if (!mSeq) mMem[mAddr] = dataIn;
        else if (mSen && !wasFull) begin
          mMem[mCount] = dataIn;
          mCount++;
        end
      end
      if (opening) mBusy = !modeSel || (addrIn[0] && !wasFull);
      else if (closing) mBusy = 0;
      if (opening && !modeSel) mOe = 0;
      else if (closing && mSeq) mOe = 1;
      if (opening) begin
        mSeq = modeSel; mSen = addrIn[0]; mAddr = addrIn;
      end
      sw3 = sw2; sw2 = sw1; sw1 = !wrN && !csN;
      sc2 = sc1; sc1 = addrIn[1];
    end
  end

  task automatic check(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // Compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 rdData", rdData, mMem[rdAddr]);
      check("R7 fullOut", fullOut, mCount == 8);
      check("R9 fullOe", fullOe, mOe && !standby);
      check("R10 wrBusy", wrBusy, mBusy);
    end
  end

  always @(negedge clk) begin
    #1 rdAddr <= rdAddr + 1'b1;
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // One bus write: hold the address for 6 cycles, then scramble it in random mode (R3)
  task automatic busWrite(bit seqMode, logic [2:0] addr, logic [5:0] code);
    waitCycles(1);
    modeSel = seqMode; addrIn = addr; dataIn = code;
    wrN = 1'b0;
    waitCycles(6);
    modeSel = ~seqMode;           // R2: late mode change ignored
    if (!seqMode) addrIn = ~addr; // R3: late address change ignored
    waitCycles(2);
    wrN = 1'b1;
    waitCycles(6);
    modeSel = seqMode;
    dataIn = ~code;
  endtask

  initial begin
    waitCycles(3);
    rst_n = 1'b1;
    waitCycles(10); // R4: reset contents all blank, flags low

    // R2 R3 R4: random writes
    busWrite(1'b0, 3'd5, 6'h01);
    busWrite(1'b0, 3'd0, 6'h3F);
    busWrite(1'b0, 3'd7, 6'h15);

    // R1: write line toggles while chip select is high, no effect
    csN = 1'b1; modeSel = 1'b0; addrIn = 3'd3; dataIn = 6'h0C;
    waitCycles(2); wrN = 1'b0; waitCycles(8); wrN = 1'b1; waitCycles(10);
    // R1: strobe formed by chip select while the write line stays low
    wrN = 1'b0; waitCycles(3); csN = 1'b0; waitCycles(8);
    addrIn = 3'd4; csN = 1'b1; waitCycles(8); wrN = 1'b1; csN = 1'b0; waitCycles(8);

    // R5 R6 R7 R9 R10: sequential fill of all eight words
    for (int k = 0; k < 8; k++) busWrite(1'b1, 3'b011, 6'(6'h10 + k));
    // R7: ninth write refused, busy stays low
    busWrite(1'b1, 3'b011, 6'h2E);

    // R11: standby silences the full driver only
    standby = 1'b1; waitCycles(12); standby = 1'b0; waitCycles(4);

    // R8: clear through the shared pin
    addrIn = 3'b001; waitCycles(6); addrIn = 3'b011; waitCycles(6);

    // R5: enable low, write ignored
    busWrite(1'b1, 3'b010, 6'h33);
    // R6: pointer restarts at word 0
    busWrite(1'b1, 3'b011, 6'h21);
    busWrite(1'b1, 3'b011, 6'h22);

    // R9: back to random, driver released at strobe open
    busWrite(1'b0, 3'b110, 6'h07);
    waitCycles(12);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule